// File: doc/BRIEF.md
# Multi-Size Set-Associative Translation Cache

This block caches virtual-to-physical page translations for three page sizes: 4 KiB, 64 KiB and 1 MiB. It is organised as 64 sets of 8 ways. A page walker writes new translations through a fill port. A client asks for translations through a lookup port and gets a registered answer one cycle later. Software-driven maintenance removes stale entries through an invalidate port, which takes one 4 KiB-aligned address per request.

The set is always picked by virtual address bits [17:12], whatever the page size. Each way stores its own size code and compares only the tag bits that lie above its page offset. As a result, one large page can sit in many different sets. A 1 MiB page can land in any of the 64 sets, and a 64 KiB page in one of 16 neighbouring sets. Each invalidate request probes a single set. To remove a 64 KiB page, the caller issues 16 requests at consecutive 4 KiB addresses inside it. To remove a 1 MiB page, the caller issues 64 such requests. Replacement inside a set is round-robin.

Top module: `tlb_msz`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and `rsp_valid`, `rsp_hit` and `rsp_multi` are low until a lookup is made.
- R2: The answer to a lookup presented with `lk_req` high at a rising edge appears on `rsp_*` right after that edge, with `rsp_valid` high for exactly that one cycle.
- R3: Size codes are 0 = 4 KiB, 1 = 64 KiB and 2 = 1 MiB. On a single hit, `rsp_size` returns the entry's code. `rsp_pa` is the stored physical frame above the page offset joined with the lookup address below it, the page offset being bit 12, 16 or 20.
- R4: A fill lands in the set named by `fill_va[17:12]`. A lookup probes only the set named by `lk_va[17:12]`, so a lookup inside a cached large page but with different index bits misses.
- R5: Each set has its own 3-bit round-robin pointer, starting at way 0. The ninth fill into one set overwrites the first one, and fills into one set never disturb another set.
- R6: An invalidate clears every valid way of the set named by `inv_va[17:12]` whose tag matches under that way's own size mask. Entries in other sets stay, even if they belong to the same page.
- R7: A lookup that matches two or more ways reports `rsp_multi` high, `rsp_hit` low and `rsp_pa` = 0.
- R8: On a miss or a multi-hit, `rsp_hit` is low and `rsp_pa` and `rsp_size` are 0.
- R9: A lookup sees the table as it stood before any fill or invalidate accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Exactly one way matched |
| rsp_multi | output | 1 | Two or more ways matched |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_size | output | 2 | Size code of the matching entry |
| fill_req | input | 1 | Fill request from the walker |
| fill_va | input | VA_W | Virtual address of the filled page |
| fill_pa | input | PA_W | Physical address of the filled page |
| fill_size | input | 2 | Size code of the filled page |
| inv_req | input | 1 | Invalidate request |
| inv_va | input | VA_W | 4 KiB-aligned address to invalidate |

## Verification
Fills and invalidates take effect at the edge that accepts them. A lookup answer is due exactly one edge after its request. The bench therefore queues each expected answer when it raises `lk_req`, and pops it at the falling edge that follows the next rising edge. An answer that arrives with nothing queued counts as a failure, and so does a queued answer that never arrives. The same-edge case drives a fill and a lookup together and expects the older table contents.

// File: rtl/tlb_msz.sv
module tlb_msz #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 64,
  parameter int WAYS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_req,
  input  logic [VA_W-1:0] lk_va,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_multi,
  output logic [PA_W-1:0] rsp_pa,
  output logic [1:0]      rsp_size,
  input  logic            fill_req,
  input  logic [VA_W-1:0] fill_va,
  input  logic [PA_W-1:0] fill_pa,
  input  logic [1:0]      fill_size,
  input  logic            inv_req,
  input  logic [VA_W-1:0] inv_va
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  logic [WAYS-1:0]  vld  [SETS];
  logic [1:0]       esz  [SETS][WAYS];
  logic [VPN_W-1:0] etag [SETS][WAYS];
  logic [PPN_W-1:0] eppn [SETS][WAYS];
  logic [WAY_W-1:0] rr   [SETS];

  wire [IDX_W-1:0] lk_set   = lk_va[IDX_W+11:12];
  wire [IDX_W-1:0] fill_set = fill_va[IDX_W+11:12];
  wire [IDX_W-1:0] inv_set  = inv_va[IDX_W+11:12];

  function automatic logic [VPN_W-1:0] vmask(input logic [1:0] sz);
    vmask = '1;
    if (sz == 2'd1) vmask[3:0] = '0;
    else if (sz == 2'd2) vmask[7:0] = '0;
  endfunction

  function automatic logic [PPN_W-1:0] pmask(input logic [1:0] sz);
    pmask = '1;
    if (sz == 2'd1) pmask[3:0] = '0;
    else if (sz == 2'd2) pmask[7:0] = '0;
  endfunction

  logic [WAYS-1:0]  hitv, inv_hit;
  logic [PPN_W-1:0] sel_ppn, pm;
  logic [1:0]       sel_sz;
  logic [PA_W-1:0]  pa_next;
  logic             one_hit, many_hit;

  always_comb begin
    sel_ppn = '0;
    sel_sz  = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitv[w] = vld[lk_set][w] &&
        (((etag[lk_set][w] ^ lk_va[VA_W-1:12]) & vmask(esz[lk_set][w])) == '0);
      inv_hit[w] = vld[inv_set][w] &&
        (((etag[inv_set][w] ^ inv_va[VA_W-1:12]) & vmask(esz[inv_set][w])) == '0);
      if (hitv[w]) begin
        sel_ppn = sel_ppn | eppn[lk_set][w];
        sel_sz  = sel_sz | esz[lk_set][w];
      end
    end
    pm       = pmask(sel_sz);
    pa_next  = {(sel_ppn & pm) | ({{(PPN_W-8){1'b0}}, lk_va[19:12]} & ~pm), lk_va[11:0]};
    one_hit  = $countones(hitv) == 1;
    many_hit = $countones(hitv) > 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_size  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && one_hit;
      rsp_multi <= lk_req && many_hit;
      rsp_pa    <= (lk_req && one_hit) ? pa_next : '0;
      rsp_size  <= (lk_req && one_hit) ? sel_sz : 2'd0;
      if (inv_req) vld[inv_set] <= vld[inv_set] & ~inv_hit;
      if (fill_req) begin
        vld[fill_set][rr[fill_set]] <= 1'b1;
        rr[fill_set] <= rr[fill_set] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_req) begin
      esz[fill_set][rr[fill_set]]  <= fill_size;
      etag[fill_set][rr[fill_set]] <= fill_va[VA_W-1:12];
      eppn[fill_set][rr[fill_set]] <= fill_pa[PA_W-1:12];
    end
  end

  // R7
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_multi));
  // R2
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_valid && !rsp_hit && !rsp_multi));
  // R5
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> rr[$past(fill_set)] == WAY_W'($past(rr[fill_set]) + 1));
  // R6
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !fill_req) |=> ((vld[$past(inv_set)] & $past(inv_hit)) == '0));
  // R3
  pa_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pa[11:0] == $past(lk_va[11:0]));
endmodule

// File: tb/sim_tlb_msz.sv
module sim_tlb_msz;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0, fill_req = 0, inv_req = 0;
  logic [31:0] lk_va = 0, fill_va = 0, fill_pa = 0, inv_va = 0;
  logic [1:0] fill_size = 0;
  logic rsp_valid, rsp_hit, rsp_multi;
  logic [31:0] rsp_pa;
  logic [1:0] rsp_size;

  typedef struct {
    logic hit; logic multi; logic [31:0] pa; logic [1:0] sz; string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_msz u0 (.clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi),
    .rsp_pa(rsp_pa), .rsp_size(rsp_size), .fill_req(fill_req), .fill_va(fill_va),
    .fill_pa(fill_pa), .fill_size(fill_size), .inv_req(inv_req), .inv_va(inv_va));

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected answer: got hit=%0b pa=%h, expected none", rsp_hit, rsp_pa);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_hit !== e.hit || rsp_multi !== e.multi || rsp_pa !== e.pa || rsp_size !== e.sz) begin
          errors++;
          $display("FAIL %s: got hit=%0b multi=%0b pa=%h sz=%0d, expected hit=%0b multi=%0b pa=%h sz=%0d",
            e.tag, rsp_hit, rsp_multi, rsp_pa, rsp_size, e.hit, e.multi, e.pa, e.sz);
        end
      end
    end
  end

  task automatic look(input logic [31:0] va, input logic h, input logic m,
                      input logic [31:0] pa, input logic [1:0] sz, input string tag);
    exp_t e;
    @(negedge clk);
    e.hit = h; e.multi = m; e.pa = pa; e.sz = sz; e.tag = tag;
    q.push_back(e);
    lk_req = 1; lk_va = va;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
    @(negedge clk);
    fill_req = 1; fill_va = va; fill_pa = pa; fill_size = sz;
    @(negedge clk);
    fill_req = 0;
  endtask

  task automatic inval(input logic [31:0] va);
    @(negedge clk);
    inv_req = 1; inv_va = va;
    @(negedge clk);
    inv_req = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_multi !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %0b%0b%0b, expected 000", rsp_valid, rsp_hit, rsp_multi);
    end
    look(32'h0000_1000, 0, 0, 0, 0, "R1 empty miss");
    // R3 4 KiB page
    fill(32'h0040_3000, 32'h8000_5000, 2'd0);
    look(32'h0040_3ABC, 1, 0, 32'h8000_5ABC, 0, "R2 R3 4K hit");
    look(32'h0040_4ABC, 0, 0, 0, 0, "R8 miss");
    // R3 R4 64 KiB page, set 53
    fill(32'h0123_5000, 32'h4567_0000, 2'd1);
    look(32'h0123_5678, 1, 0, 32'h4567_5678, 1, "R3 64K hit");
    look(32'h0123_6000, 0, 0, 0, 0, "R4 64K other set");
    // 1 MiB page, set 7
    fill(32'h0550_7000, 32'h9A00_0000, 2'd2);
    look(32'h0558_7123, 1, 0, 32'h9A08_7123, 2, "R3 1M hit");
    look(32'h0550_8000, 0, 0, 0, 0, "R4 1M other set");
    // R7 overlap
    fill(32'h0558_7000, 32'h1111_1000, 2'd0);
    look(32'h0558_7004, 0, 1, 0, 0, "R7 multi-hit");
    inval(32'h0558_7000);
    look(32'h0550_7010, 0, 0, 0, 0, "R6 both cleared");
    // R6 64K survives other-set invalidate
    inval(32'h0123_6000);
    look(32'h0123_5010, 1, 0, 32'h4567_5010, 1, "R6 other set kept");
    for (int i = 0; i < 16; i++) inval(32'h0123_0000 + i * 32'h1000);
    look(32'h0123_5010, 0, 0, 0, 0, "R6 64K removed");
    // R5 round robin in set 9, neighbour set 10
    fill(32'h0000_A000, 32'h2222_2000, 2'd0);
    for (int k = 0; k < 9; k++) fill(32'h0000_9000 + k * 32'h4_0000, 32'h7000_0000 + k * 32'h1000, 2'd0);
    look(32'h0000_9ABC, 0, 0, 0, 0, "R5 oldest evicted");
    look(32'h0004_9ABC, 1, 0, 32'h7000_1ABC, 0, "R5 second kept");
    look(32'h0020_9ABC, 1, 0, 32'h7000_8ABC, 0, "R5 newest");
    look(32'h0000_A123, 1, 0, 32'h2222_2123, 0, "R5 other set kept");
    // R9 same-edge fill and lookup
    begin
      exp_t e;
      @(negedge clk);
      e.hit = 0; e.multi = 0; e.pa = 0; e.sz = 0; e.tag = "R9 sees old table";
      q.push_back(e);
      lk_req = 1; lk_va = 32'h0003_3456;
      fill_req = 1; fill_va = 32'h0003_3000; fill_pa = 32'h3333_3000; fill_size = 0;
      @(negedge clk);
      lk_req = 0; fill_req = 0;
    end
    look(32'h0003_3456, 1, 0, 32'h3333_3456, 0, "R9 fill visible next");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing answers: got %0d pending, expected 0", q.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end
endmodule